// File: doc/BRIEF.md
# XOR-Reconfigurable Macrocell Register Bank

This block is a bank of four output macrocells. Each cell takes one sum-of-products result and one second operand. A 2-bit mode selects how the cell behaves. It can be a combinational output, a D flip-flop, a T flip-flop or a J-K flip-flop. All the registered behaviours come from one storage bit whose next value is formed by an exclusive-OR ahead of it. Each cell also has a fast-path bit. When that bit is set, the second operand has no path into the cell, and a registered cell simply loads the sum-of-products result.

Each cell's storage bit is a two-state machine, `QS_LOW` and `QS_HIGH`. Four transitions act on it:
- SET moves it from `QS_LOW` to `QS_HIGH`.
- CLEAR moves it from `QS_HIGH` to `QS_LOW`.
- HOLD keeps the current state.
- RESET is asynchronous and forces `QS_LOW` from either state.

The four cells share their controls. One select field picks the clock for all four registers: one of three global clocks or a local product-term clock. The reset is the OR of a global reset pin, which is always active, and a local product-term reset that has its own enable. The block is used behind a product-term array, and the array itself is not part of this block.

Top module: `mc_bank`

## Requirements
- R1: Each cell k takes its mode from `mode_i[2k+1:2k]`. The encodings are 0 = combinational, 1 = D, 2 = T and 3 = J-K.
- R2: In combinational mode, `q_o[k]` follows `sop_i[k] ^ xop_i[k]` with no clock. When `bypass_i[k]` is 1, it follows `sop_i[k]` alone.
- R3: In D mode, at a selected clock edge, the cell takes the state `sop_i[k] ^ xop_i[k]`.
- R4: In T mode, at a selected clock edge, the state inverts when `sop_i[k]` is 1 and is held when it is 0.
- R5: In J-K mode, J is `sop_i[k]` and K is `xop_i[k]`. At a selected clock edge, J=1 with K=0 sets the state and J=0 with K=1 clears it. J=K=1 inverts the state, and J=K=0 holds it.
- R6: In any registered mode with `bypass_i[k]` = 1, the second operand has no effect, and the cell loads `sop_i[k]` at a selected clock edge.
- R7: `clk_sel_i` picks the register clock for all four cells: 0, 1 and 2 pick `gclk_i[0]`, `gclk_i[1]` and `gclk_i[2]`, and 3 picks `ptclk_i`. Edges on the clocks that are not selected change nothing.
- R8: While `grst_i` is 1, or while `ptrst_i` and `ptrst_en_i` are both 1, every register is forced to 0 with no clock edge needed. This reset overrides any clock edge.
- R9: When `ptrst_en_i` is 0, `ptrst_i` has no effect.
- R10: After reset, every cell in a registered mode shows 0 on `q_o`.
- R11: A cell in combinational mode keeps its stored state across clock edges. The stored state shows again on `q_o` when the cell returns to a registered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk_i | input | NGCLK (3) | Global clocks |
| ptclk_i | input | 1 | Local product-term clock |
| clk_sel_i | input | SEL_W (2) | Register clock select, shared by all cells |
| grst_i | input | 1 | Global asynchronous reset, active high |
| ptrst_i | input | 1 | Local product-term reset |
| ptrst_en_i | input | 1 | Enable for the local reset |
| mode_i | input | 2*NCELL (8) | Per-cell mode, 2 bits per cell |
| bypass_i | input | NCELL (4) | Per-cell fast path that removes the XOR operand |
| sop_i | input | NCELL (4) | Per-cell sum-of-products result |
| xop_i | input | NCELL (4) | Per-cell second operand (K in J-K mode) |
| q_o | output | NCELL (4) | Per-cell output |

## Verification
A wrong stored state in a cell only shows at `q_o` while that cell is in a registered mode. It shows in the same cycle as the faulty clock edge, and it persists, because T and J-K modes feed the state back into the next value. A state hidden in combinational mode shows only when the cell returns to a registered mode. For that reason, the bench switches cells out of combinational mode without a clock edge and compares the held value at once. A reset that waited for a clock would show as a nonzero output in the cycle after reset rises with all clocks idle. So the bench asserts reset during idle-clock cycles.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_COMB = 2'd0,
        MD_DFF  = 2'd1,
        MD_TFF  = 2'd2,
        MD_JK   = 2'd3
    } cell_mode_t;

    typedef enum logic {
        QS_LOW  = 1'b0,
        QS_HIGH = 1'b1
    } qstate_t;

endpackage

// File: rtl/mc_clk_ctrl.sv
module mc_clk_ctrl #(
    parameter int NGCLK = 3,
    parameter int SEL_W = 2
) (
    input  logic [NGCLK-1:0] gclk_i,
    input  logic             ptclk_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             grst_i,
    input  logic             ptrst_i,
    input  logic             ptrst_en_i,
    output logic             rclk_o,
    output logic             arst_o
);
    localparam int NSRC = 1 << SEL_W;

    logic [NSRC-1:0] src;

    // Select codes below NGCLK reach a global clock; every higher code reaches the local clock.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i < NGCLK) begin : g_glob
            assign src[i] = gclk_i[i];
        end else begin : g_local
            assign src[i] = ptclk_i;
        end
    end

    assign rclk_o = src[sel_i];

    // The global pin always acts; the local term acts only when enabled.
    assign arst_o = grst_i | (ptrst_en_i & ptrst_i);

endmodule

// File: rtl/mc_next.sv
module mc_next
    import mc_pkg::*;
(
    input  cell_mode_t mode_i,
    input  logic       byp_i,
    input  logic       sop_i,
    input  logic       xop_i,
    input  qstate_t    cur_i,
    output qstate_t    nxt_o
);
    logic go_high;
    logic go_low;
    logic d_in;

    // Conditions for the SET and CLEAR transitions
    always_comb begin
        d_in    = sop_i ^ (xop_i & ~byp_i);
        go_high = 1'b0;
        go_low  = 1'b0;
        if (byp_i && mode_i != MD_COMB) begin
            go_high = sop_i;
            go_low  = ~sop_i;
        end else begin
            unique case (mode_i)
                MD_COMB: begin
                    go_high = 1'b0;
                    go_low  = 1'b0;
                end
                MD_DFF: begin
                    go_high = d_in;
                    go_low  = ~d_in;
                end
                MD_TFF: begin
                    go_high = sop_i;
                    go_low  = sop_i;
                end
                MD_JK: begin
                    go_high = sop_i;
                    go_low  = xop_i;
                end
            endcase
        end
    end

    // State transitions: SET, CLEAR, HOLD
    always_comb begin
        unique case (cur_i)
            QS_LOW:  nxt_o = go_high ? QS_HIGH : QS_LOW;
            QS_HIGH: nxt_o = go_low  ? QS_LOW  : QS_HIGH;
        endcase
    end

endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
(
    input  logic       clk_i,
    input  logic       arst_i,
    input  cell_mode_t mode_i,
    input  logic       byp_i,
    input  logic       sop_i,
    input  logic       xop_i,
    output logic       q_o
);
    qstate_t st;
    qstate_t st_nxt;

    mc_next u_next (
        .mode_i (mode_i),
        .byp_i  (byp_i),
        .sop_i  (sop_i),
        .xop_i  (xop_i),
        .cur_i  (st),
        .nxt_o  (st_nxt)
    );

    // State register; RESET wins over any clock edge
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            st <= QS_LOW;
        end else begin
            st <= st_nxt;
        end
    end

    // Output: the combinational path or the stored state
    always_comb begin
        unique case (mode_i)
            MD_COMB: q_o = sop_i ^ (xop_i & ~byp_i);
            default: q_o = (st == QS_HIGH);
        endcase
    end

endmodule

// File: rtl/mc_bank.sv
module mc_bank
    import mc_pkg::*;
#(
    parameter  int NCELL = 4,
    parameter  int NGCLK = 3,
    localparam int SEL_W = $clog2(NGCLK + 1)
) (
    input  logic [NGCLK-1:0]        gclk_i,
    input  logic                    ptclk_i,
    input  logic [SEL_W-1:0]        clk_sel_i,
    input  logic                    grst_i,
    input  logic                    ptrst_i,
    input  logic                    ptrst_en_i,
    input  logic [NCELL*MODE_W-1:0] mode_i,
    input  logic [NCELL-1:0]        bypass_i,
    input  logic [NCELL-1:0]        sop_i,
    input  logic [NCELL-1:0]        xop_i,
    output logic [NCELL-1:0]        q_o
);
    logic reg_clk;
    logic arst;

    mc_clk_ctrl #(
        .NGCLK (NGCLK),
        .SEL_W (SEL_W)
    ) u_ctrl (
        .gclk_i     (gclk_i),
        .ptclk_i    (ptclk_i),
        .sel_i      (clk_sel_i),
        .grst_i     (grst_i),
        .ptrst_i    (ptrst_i),
        .ptrst_en_i (ptrst_en_i),
        .rclk_o     (reg_clk),
        .arst_o     (arst)
    );

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        mc_cell u_cell (
            .clk_i  (reg_clk),
            .arst_i (arst),
            .mode_i (cell_mode_t'(mode_i[k*MODE_W +: MODE_W])),
            .byp_i  (bypass_i[k]),
            .sop_i  (sop_i[k]),
            .xop_i  (xop_i[k]),
            .q_o    (q_o[k])
        );
    end

endmodule

// File: rtl/mc_bank_chk.sv
module mc_bank_chk
    import mc_pkg::*;
#(
    parameter int NCELL = 4
) (
    input logic                    rclk,
    input logic                    arst,
    input logic [NCELL*MODE_W-1:0] mode_i,
    input logic [NCELL-1:0]        bypass_i,
    input logic [NCELL-1:0]        sop_i,
    input logic [NCELL-1:0]        xop_i,
    input logic [NCELL-1:0]        q_o
);
    // Set when a reset has happened since the previous register clock edge
    logic rst_seen;
    always_ff @(posedge rclk or posedge arst) begin
        if (arst) rst_seen <= 1'b1;
        else      rst_seen <= 1'b0;
    end

    for (genvar k = 0; k < NCELL; k++) begin : g_chk
        logic [MODE_W-1:0] md;
        assign md = mode_i[k*MODE_W +: MODE_W];

        // R8 / R10: a registered cell reads 0 at any clock edge while reset is held
        always @(posedge rclk) begin
            if (arst && md != MD_COMB) begin
                a_r8_reset_zero: assert (q_o[k] == 1'b0);
            end
        end

        a_r3_d_load: assert property (@(posedge rclk) disable iff (arst)
            (md == MD_DFF && !bypass_i[k]) |=>
            (rst_seen || md == MD_COMB || q_o[k] == $past(sop_i[k] ^ xop_i[k])));

        a_r4_toggle: assert property (@(posedge rclk) disable iff (arst)
            (md == MD_TFF && !bypass_i[k]) |=>
            (rst_seen || md == MD_COMB || q_o[k] == ($past(q_o[k]) ^ $past(sop_i[k]))));

        a_r5_jk: assert property (@(posedge rclk) disable iff (arst)
            (md == MD_JK && !bypass_i[k] && sop_i[k] != xop_i[k]) |=>
            (rst_seen || md == MD_COMB || q_o[k] == $past(sop_i[k])));

        a_r6_bypass_load: assert property (@(posedge rclk) disable iff (arst)
            (md != MD_COMB && bypass_i[k]) |=>
            (rst_seen || md == MD_COMB || q_o[k] == $past(sop_i[k])));
    end

endmodule

bind mc_bank mc_bank_chk #(
    .NCELL (NCELL)
) u_chk (
    .rclk     (reg_clk),
    .arst     (arst),
    .mode_i   (mode_i),
    .bypass_i (bypass_i),
    .sop_i    (sop_i),
    .xop_i    (xop_i),
    .q_o      (q_o)
);

// File: tb/mc_bank_bench.sv
`timescale 1ns/1ps
module mc_bank_bench;
    localparam int NC = 4;

    logic       clk = 1'b0;
    logic [3:0] pulse = 4'h0;     // bits 0..2 global clocks, bit 3 local clock
    logic [1:0] clk_sel = 2'd0;
    logic       grst = 1'b1;
    logic       ptrst = 1'b0;
    logic       ptrst_en = 1'b0;
    logic [7:0] mode = 8'h55;
    logic [3:0] byp = 4'h0;
    logic [3:0] sop = 4'h0;
    logic [3:0] xop = 4'h0;
    logic [3:0] q;
    logic [2:0] gclk;
    logic       ptclk;

    logic [3:0]  refq = 4'h0;
    logic [31:0] seed = 32'h1234_5678;
    int          checks = 0;
    int          errors = 0;
    bit          run = 1'b0;
    bit          done = 1'b0;
    string       phase = "R10 reset state";

    always #2 clk = ~clk;

    assign gclk  = pulse[2:0] & {3{clk}};
    assign ptclk = pulse[3] & clk;

    mc_bank u_mc_bank (
        .gclk_i     (gclk),
        .ptclk_i    (ptclk),
        .clk_sel_i  (clk_sel),
        .grst_i     (grst),
        .ptrst_i    (ptrst),
        .ptrst_en_i (ptrst_en),
        .mode_i     (mode),
        .bypass_i   (byp),
        .sop_i      (sop),
        .xop_i      (xop),
        .q_o        (q)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        logic [3:0] nq;
        nq = refq;
        if (grst || (ptrst_en && ptrst)) begin
            nq = 4'h0;
        end else if (pulse[clk_sel]) begin
            for (int k = 0; k < NC; k++) begin
                int m;
                m = int'(mode[2*k +: 2]);
                if (m == 0)            nq[k] = refq[k];
                else if (byp[k])       nq[k] = sop[k];
                else if (m == 1)       nq[k] = sop[k] ^ xop[k];
                else if (m == 2)       nq[k] = sop[k] ? !refq[k] : refq[k];
                else begin
                    if (sop[k] && xop[k]) nq[k] = !refq[k];
                    else if (sop[k])      nq[k] = 1'b1;
                    else if (xop[k])      nq[k] = 1'b0;
                    else                  nq[k] = refq[k];
                end
            end
        end
        refq = nq;
    end

    function automatic logic exp_bit(int k);
        if (mode[2*k +: 2] == 2'd0) return sop[k] ^ (xop[k] & ~byp[k]);
        return refq[k];
    endfunction

    function automatic string cell_tag(int k);
        if (mode[2*k +: 2] == 2'd0) return "R2";
        if (byp[k])                 return "R6";
        if (mode[2*k +: 2] == 2'd1) return "R3";
        if (mode[2*k +: 2] == 2'd2) return "R4";
        return "R5";
    endfunction

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (run) begin
            for (int k = 0; k < NC; k++) begin
                logic e;
                e = exp_bit(k);
                checks++;
                if (q[k] !== e) begin
                    errors++;
                    $display("FAIL %s (phase %s) R1 cell %0d actual %b expected %b",
                             cell_tag(k), phase, k, q[k], e);
                end
            end
        end
    end

    task automatic nc();
        @(negedge clk);
        #1;
    endtask

    task automatic rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
    endtask

    task automatic load_ones();
        nc(); grst = 1'b0; ptrst = 1'b0; ptrst_en = 1'b0;
        mode = 8'h55; byp = 4'h0; sop = 4'hF; xop = 4'h0; pulse = 4'hF;
        nc(); pulse = 4'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        run = 1'b1;
        // R10: reset held with every clock pulsing, D data of 1
        for (int i = 0; i < 3; i++) begin
            nc(); pulse = 4'hF; sop = 4'hF;
        end
        nc(); grst = 1'b0; pulse = 4'h0;

        phase = "R3 D mode";
        mode = 8'h55; clk_sel = 2'd0;
        for (int i = 0; i < 20; i++) begin
            nc(); rnd(); sop = seed[19:16]; xop = seed[23:20]; pulse = seed[27:24];
        end

        phase = "R4 T mode";
        mode = 8'hAA; clk_sel = 2'd1;
        for (int i = 0; i < 20; i++) begin
            nc(); rnd(); sop = seed[19:16]; xop = seed[23:20]; pulse = seed[27:24];
        end

        phase = "R5 JK mode";
        mode = 8'hFF; clk_sel = 2'd2;
        for (int i = 0; i < 24; i++) begin
            nc(); rnd(); sop = seed[19:16]; xop = seed[23:20]; pulse = 4'hF;
        end

        phase = "R2 R6 mixed";
        clk_sel = 2'd3;
        for (int i = 0; i < 40; i++) begin
            nc(); rnd(); sop = seed[19:16]; xop = seed[23:20];
            pulse = seed[27:24]; byp = seed[31:28]; mode = seed[15:8];
        end

        phase = "R7 unselected clocks";
        load_ones();
        byp = 4'h0; clk_sel = 2'd0;
        for (int i = 0; i < 8; i++) begin
            nc(); rnd(); sop = seed[19:16]; xop = seed[23:20]; pulse = 4'b1110;
        end
        clk_sel = 2'd3;
        for (int i = 0; i < 8; i++) begin
            nc(); rnd(); sop = seed[19:16]; xop = seed[23:20]; pulse = 4'b0111;
        end
        nc(); pulse = 4'b1000; sop = 4'h5; xop = 4'h0;

        phase = "R8 async global reset";
        load_ones();
        grst = 1'b1;
        nc(); grst = 1'b0;
        phase = "R8 async local reset";
        load_ones();
        ptrst_en = 1'b1; ptrst = 1'b1;
        nc(); ptrst = 1'b0;
        phase = "R8 reset over clock edge";
        load_ones();
        grst = 1'b1; sop = 4'hF; pulse = 4'hF;
        nc(); pulse = 4'h0; grst = 1'b0;

        phase = "R9 local reset disabled";
        load_ones();
        ptrst_en = 1'b0; ptrst = 1'b1; clk_sel = 2'd1;
        for (int i = 0; i < 10; i++) begin
            nc(); rnd(); sop = seed[19:16]; xop = seed[23:20]; pulse = seed[27:24];
        end
        nc(); ptrst = 1'b0;

        phase = "R11 hold in combinational mode";
        nc(); rnd(); clk_sel = 2'd0; mode = 8'h55; byp = 4'h0;
        sop = seed[19:16]; xop = 4'h0; pulse = 4'hF;
        nc(); mode = 8'h00; pulse = 4'h0;
        for (int i = 0; i < 8; i++) begin
            nc(); rnd(); sop = seed[19:16]; xop = seed[23:20]; pulse = 4'hF;
        end
        nc(); mode = 8'h55; pulse = 4'h0;
        nc();
        nc();

        done = 1'b1;
        run = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule